// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block divides one integer by another, one quotient bit per clock. It works on operands of `W` bits, 32 by default. A request carries a dividend, a divisor, a select for two's-complement or unsigned operands, and a select for the short-quotient mode. In that mode the quotient is also tested against a half-width range. The block returns the quotient and the remainder together with three condition flags: V (overflow), Z (zero) and N (negative).

A request is offered with `req_valid` and is taken on a rising edge where `req_ready` is high. `req_ready` is low for as long as `busy` is high, so a request offered during a division is dropped and is never queued. The result side has no back-pressure. `done` pulses for one cycle, and the result registers then hold their values until the next completion. A zero divisor skips the iteration. It completes with `div_zero` instead of a result, and every result register keeps its earlier contents.

Top module: `intdiv_flags`

## Requirements
- R1: Unsigned mode (`is_signed`=0) with a nonzero divisor returns the floor quotient and the remainder, which is less than the divisor.
- R2: Signed mode rounds the quotient toward zero, and a nonzero remainder has the sign of the dividend. The most negative dividend divided by -1 gives the most negative value as the quotient and a remainder of 0.
- R3: A zero divisor raises `div_zero` together with `done` for one cycle, one clock edge after the accepting edge. The quotient, remainder and all three flags keep their previous values.
- R4: On a completed divide, Z is 1 exactly when the quotient is zero. N is 1 exactly when the quotient is nonzero and its top bit is 1.
- R5: In short-quotient unsigned mode, V is 1 when the quotient exceeds 2^(W/2)-1.
- R6: In short-quotient signed mode, V is 1 when the quotient, read as signed, lies outside -2^(W/2-1) to 2^(W/2-1)-1.
- R7: With `word_mode`=0, V is 0 after every completed divide.
- R8: For a nonzero divisor, `done` rises W+1 clock edges after the accepting edge and stays high for exactly one cycle. The quotient and remainder change only on the edge that raises `done`.
- R9: `busy` is high from the accepting edge until the edge that raises `done`, and `req_ready` is low during that time. A request offered while busy is dropped: it yields no second `done` and does not alter the result in progress.
- R10: After reset, `busy`, `done`, `div_zero` and all flags are 0, the quotient and remainder are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Division request offered |
| req_ready | output | 1 | Request is accepted on this edge when high |
| dividend | input | W | Dividend |
| divisor | input | W | Divisor |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| word_mode | input | 1 | 1: test the quotient against the half-width range for V |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divide-by-zero exception, pulses with `done` |
| quotient | output | W | Quotient of the last completed divide |
| remainder | output | W | Remainder of the last completed divide |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The accepting edge is the rising edge on which `req_valid` and `req_ready` are both high. Counting from that edge, a nonzero divisor raises `done` on edge W+1 and a zero divisor raises `div_zero` with `done` on edge 1. The bench counts edges from the accepting edge and samples every output on the falling edge after each one. It compares the edge on which `done` is first seen with the expected count, checks quotient, remainder and flags in that cycle, and checks one cycle later that `done` has fallen again. Requests injected mid-division are followed by a quiet window of W+3 edges, and no `done` may appear in it.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic v;
    logic z;
    logic n;
  } div_flags_t;
endpackage

// File: rtl/intdiv_operand_prep.sv
module intdiv_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic         signed_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         num_neg_o,
  output logic         den_neg_o
);
  // Magnitudes are unsigned W-bit values; the most negative input maps to 2^(W-1).
  always_comb begin
    num_neg_o = signed_i & num_i[W-1];
    den_neg_o = signed_i & den_i[W-1];
    num_mag_o = num_neg_o ? (~num_i + 1'b1) : num_i;
    den_mag_o = den_neg_o ? (~den_i + 1'b1) : den_i;
  end
endmodule

// File: rtl/intdiv_step.sv
module intdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] part_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  // One restoring iteration: shift in the next dividend bit and subtract when it fits.
  always_comb begin
    shifted = {part_i, quo_i[W-1]};
    trial   = shifted - {1'b0, den_i};
    fits    = ~trial[W];
    part_o  = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/intdiv_finish.sv
module intdiv_finish #(
  parameter int W = 32
) (
  input  logic [W-1:0]            q_mag_i,
  input  logic [W-1:0]            r_mag_i,
  input  logic                    q_neg_i,
  input  logic                    r_neg_i,
  input  logic                    signed_i,
  input  logic                    word_i,
  output logic [W-1:0]            quo_o,
  output logic [W-1:0]            rem_o,
  output intdiv_pkg::div_flags_t  flags_o
);
  localparam int HALF = W / 2;

  logic short_ovf;

  always_comb begin
    quo_o = q_neg_i ? (~q_mag_i + 1'b1) : q_mag_i;
    rem_o = r_neg_i ? (~r_mag_i + 1'b1) : r_mag_i;
  end

  // Short-quotient range test: unsigned needs empty upper half,
  // signed needs the upper half plus the half sign bit to be all equal.
  generate
    if (HALF >= 1) begin : g_range
      logic [W-HALF-1:0] hi_u;
      logic [W-HALF:0]   hi_s;
      always_comb begin
        hi_u = quo_o[W-1:HALF];
        hi_s = quo_o[W-1:HALF-1];
        if (signed_i) short_ovf = ~((&hi_s) | ~(|hi_s));
        else          short_ovf = |hi_u;
      end
    end
  endgenerate

  always_comb begin
    flags_o.v = word_i & short_ovf;
    flags_o.z = ~(|quo_o);
    flags_o.n = (|quo_o) & quo_o[W-1];
  end
endmodule

// File: rtl/intdiv_flags.sv
module intdiv_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         word_mode,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_n
);
  import intdiv_pkg::*;

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  div_state_e       state;
  logic [CNT_W-1:0] step_cnt;
  logic [W-1:0]     part_r, quo_r, den_r;
  logic             q_neg_r, r_neg_r, sgn_r, word_r, zero_r;

  logic [W-1:0]     num_mag, den_mag;
  logic             num_neg, den_neg;
  logic [W-1:0]     part_nx, quo_nx;
  logic [W-1:0]     quo_fin, rem_fin;
  div_flags_t       flags_fin;
  div_flags_t       flags_r;
  logic             take;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign take      = req_valid & req_ready;
  assign flag_v    = flags_r.v;
  assign flag_z    = flags_r.z;
  assign flag_n    = flags_r.n;

  intdiv_operand_prep #(.W(W)) u_prep (
    .num_i     (dividend),
    .den_i     (divisor),
    .signed_i  (is_signed),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag),
    .num_neg_o (num_neg),
    .den_neg_o (den_neg)
  );

  intdiv_step #(.W(W)) u_step (
    .part_i (part_r),
    .quo_i  (quo_r),
    .den_i  (den_r),
    .part_o (part_nx),
    .quo_o  (quo_nx)
  );

  intdiv_finish #(.W(W)) u_finish (
    .q_mag_i  (quo_r),
    .r_mag_i  (part_r),
    .q_neg_i  (q_neg_r),
    .r_neg_i  (r_neg_r),
    .signed_i (sgn_r),
    .word_i   (word_r),
    .quo_o    (quo_fin),
    .rem_o    (rem_fin),
    .flags_o  (flags_fin)
  );

  // Control: accept, iterate W steps, then one fix-up/commit cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      part_r   <= '0;
      quo_r    <= '0;
      den_r    <= '0;
      q_neg_r  <= 1'b0;
      r_neg_r  <= 1'b0;
      sgn_r    <= 1'b0;
      word_r   <= 1'b0;
      zero_r   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            part_r   <= '0;
            quo_r    <= num_mag;
            den_r    <= den_mag;
            q_neg_r  <= num_neg ^ den_neg;
            r_neg_r  <= num_neg;
            sgn_r    <= is_signed;
            word_r   <= word_mode;
            zero_r   <= ~(|divisor);
            step_cnt <= '0;
            state    <= (|divisor) ? ST_RUN : ST_FIX;
          end
        end
        ST_RUN: begin
          part_r   <= part_nx;
          quo_r    <= quo_nx;
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Result registers: written only on a completing nonzero divide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      flags_r   <= '0;
    end else begin
      done     <= (state == ST_FIX);
      div_zero <= (state == ST_FIX) & zero_r;
      if ((state == ST_FIX) && !zero_r) begin
        quotient  <= quo_fin;
        remainder <= rem_fin;
        flags_r   <= flags_fin;
      end
    end
  end
endmodule

// File: rtl/intdiv_flags_chk.sv
module intdiv_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         flag_v,
  input logic         flag_z,
  input logic         flag_n
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  zero_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);

  // R3
  zero_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> ($stable(quotient) && $stable(remainder) &&
                  $stable(flag_v) && $stable(flag_z) && $stable(flag_n)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (flag_z == (quotient == '0)));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_z && flag_n));
endmodule

bind intdiv_flags intdiv_flags_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .div_zero  (div_zero),
  .quotient  (quotient),
  .remainder (remainder),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/intdiv_flags_bench.sv
module intdiv_flags_bench;
  localparam int W    = 8;
  localparam int HALF = W / 2;
  localparam int MODM = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         is_signed = 1'b0;
  logic         word_mode = 1'b0;
  logic         busy, done, div_zero, flag_v, flag_z, flag_n;
  logic [W-1:0] quotient, remainder;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q = 0, exp_r = 0, exp_v = 0, exp_z = 0, exp_n = 0;

  always #10 clk = ~clk;

  intdiv_flags #(.W(W)) u_intdiv_flags (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed),
    .word_mode(word_mode), .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder),
    .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic int aval(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 127; 3: return 128;
      4: return 255; 5: return 129; 6: return 7;   7: return 8;
      default: return (i * 53 + 11) % MODM;
    endcase
  endfunction

  function automatic int bval(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 255; 3: return 128;
      4: return 127; 5: return 2;   6: return 254; 7: return 16;
      default: return (i * 29 + 3) % MODM;
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v >= MODM / 2) ? v - MODM : v;
  endfunction

  task automatic run_op(input int a, input int b, input bit sgn, input bit wm,
                        input bit intrude);
    int qi, ri, cnt, qw;
    bit zero;
    zero = (b == 0);
    if (!zero) begin
      if (sgn) begin qi = sx(a) / sx(b); ri = sx(a) % sx(b); end
      else     begin qi = a / b;         ri = a % b;         end
      qw = ((qi % MODM) + MODM) % MODM;
      exp_q = qw;
      exp_r = ((ri % MODM) + MODM) % MODM;
      exp_z = (qw == 0);
      exp_n = (qw != 0) && (qw >= MODM / 2);
      if (!wm)      exp_v = 0;
      else if (sgn) exp_v = (qi > (1 << (HALF-1)) - 1) || (qi < -(1 << (HALF-1)));
      else          exp_v = (qi > (1 << HALF) - 1);
    end
    @(negedge clk);
    chk("R9 ready before request", int'(req_ready), 1);
    dividend  = a[W-1:0];
    divisor   = b[W-1:0];
    is_signed = sgn;
    word_mode = wm;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (intrude && cnt == 2) begin
        chk("R9 ready low while busy", int'(req_ready), 0);
        dividend  = 8'h5A;
        divisor   = 8'h03;
        req_valid = 1'b1;
      end
      if (intrude && cnt == 3) req_valid = 1'b0;
    end while (!done && cnt < W + 8);
    if (zero) begin
      chk("R3 zero-divisor latency", cnt, 1);
      chk("R3 div_zero raised", int'(div_zero), 1);
    end else begin
      chk("R8 done latency", cnt, W + 1);
      chk("R3 div_zero quiet", int'(div_zero), 0);
    end
    chk(sgn ? "R2 quotient" : "R1 quotient", int'(quotient), exp_q);
    chk(sgn ? "R2 remainder" : "R1 remainder", int'(remainder), exp_r);
    chk("R4 Z flag", int'(flag_z), exp_z);
    chk("R4 N flag", int'(flag_n), exp_n);
    chk(!wm ? "R7 V flag" : (sgn ? "R6 V flag" : "R5 V flag"), int'(flag_v), exp_v);
    chk("R9 busy low at done", int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    if (intrude) begin
      for (int k = 0; k < W + 3; k++) begin
        @(posedge clk);
        @(negedge clk);
        chk("R9 dropped request gives no done", int'(done), 0);
      end
      chk("R9 result kept", int'(quotient), exp_q);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 div_zero", int'(div_zero), 0);
    chk("R10 ready", int'(req_ready), 1);
    chk("R10 quotient", int'(quotient), 0);
    chk("R10 remainder", int'(remainder), 0);
    chk("R10 flags", int'({flag_v, flag_z, flag_n}), 0);

    // R2 corner: most negative / -1 in both widths
    run_op(128, 255, 1'b1, 1'b0, 1'b0);
    run_op(128, 255, 1'b1, 1'b1, 1'b0);
    // R3: zero divisor after a known result keeps it
    run_op(200, 7, 1'b0, 1'b1, 1'b0);
    run_op(99, 0, 1'b1, 1'b0, 1'b0);
    // R9: requests during a division are dropped
    run_op(77, 5, 1'b0, 1'b0, 1'b1);
    run_op(sx(200) + MODM, 3, 1'b1, 1'b1, 1'b1);

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 40; i++)
        for (int j = 0; j < 24; j++)
          run_op(aval(i), bval(j), m[0], m[1], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule